// File: doc/BRIEF.md
# Lane Swizzle Permute Unit

This block moves 32-bit values between the 32 lanes of a SIMD group. For every destination lane it works out which source lane to read. It then applies the group's active mask and registers the permuted result, so `out_valid` follows `in_valid` by one clock. It computes lane mappings only. Decoding the pattern from an instruction, and any memory traffic, belong to the logic around it.

Five mapping modes are available:

- **Quad permute:** a free choice of source inside each group of four lanes.
- **Bit-level lane-id transform:** the id is ANDed, ORed and XORed with three 5-bit masks.
- **Group broadcast:** one lane's value goes to every lane of its group.
- **Neighbour-group swap:** adjacent groups trade places.
- **Group reverse:** lane order is mirrored inside each group.

A lane whose chosen source lane is inactive receives zero. A pattern that cannot be carried out raises an error flag and passes the input data through unchanged. Three things count as such a pattern: an unknown mode code, a group size the mode does not allow, and a broadcast index outside its group.

Top module: `lswz_unit`

## Requirements
- R1: While `rst` is high, at each clock edge `out_valid`, `cfg_err_o` and all of `lane_data_o` are cleared to zero.
- R2: `out_valid` is high exactly one clock after a cycle with `in_valid` high. `lane_data_o` and `cfg_err_o` change only on a clock edge where `in_valid` is high, and keep their value otherwise.
- R3: Mode code 0 (quad permute): destination lane d reads lane `{d[4:2], q}`. Here q is `quad_sel_i[2p+1:2p]` and p = d[1:0].
- R4: Mode code 1 (lane-id transform): destination lane d reads lane `((d & and_mask_i) | or_mask_i) ^ xor_mask_i`. This gives each id bit the choice of being cleared, set, kept or inverted.
- R5: Mode code 2 (broadcast): with group size G = 2^`grp_log2_i`, where `grp_log2_i` is in 1..5, every lane d reads lane `(d - d mod G) + bcast_idx_i`.
- R6: Mode code 3 (swap): with G = 2^`grp_log2_i`, where `grp_log2_i` is in 0..4, lane d reads lane d+G if `floor(d/G)` is even, and lane d-G otherwise.
- R7: Mode code 4 (reverse): with G = 2^`grp_log2_i`, where `grp_log2_i` is in 1..5, lane d reads lane `(d - d mod G) + (G-1) - (d mod G)`.
- R8: In a valid pattern, a destination lane whose source lane has a 0 bit in `active_i` receives zero. Otherwise it receives the source lane's word (lane k occupies bits [32k+31:32k]).
- R9: In broadcast mode with a legal group size, a `bcast_idx_i` of G or more sets `cfg_err_o`. Every lane then outputs its own input word, with the active mask not applied.
- R10: Mode codes 5 to 7, a swap `grp_log2_i` above 4, and a broadcast or reverse `grp_log2_i` of 0 or above 5 each set `cfg_err_o` and pass the input words through unchanged. A valid pattern clears `cfg_err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Inputs carry an operation to perform |
| lane_data_i | input | 1024 | 32 lane words, lane k at bits [32k+31:32k] |
| active_i | input | 32 | Active mask, bit k for lane k |
| mode_i | input | 3 | Mapping mode code |
| quad_sel_i | input | 8 | Quad permute selectors, 2 bits per position |
| and_mask_i | input | 5 | Lane-id AND mask |
| or_mask_i | input | 5 | Lane-id OR mask |
| xor_mask_i | input | 5 | Lane-id XOR mask |
| grp_log2_i | input | 3 | Base-2 logarithm of the group size |
| bcast_idx_i | input | 5 | Broadcast source lane within its group |
| out_valid | output | 1 | Registered result is new this cycle |
| lane_data_o | output | 1024 | Permuted lane words |
| cfg_err_o | output | 1 | Pattern was rejected and data passed through |

## Verification
The hardest situation to reach is a destination lane that reads an inactive source, because the zero only shows when the mapping and the mask line up. The stimulus therefore pairs known mappings with masks that target them:
- a half-empty mask under a full-width reverse;
- a mask with lane 0 cleared while every lane is forced to read lane 0;
- a lane mask that gaps out alternate quads.

The rejected-broadcast cases use a partial mask, which shows that passthrough bypasses the masking.

// File: rtl/lswz_pkg.sv
package lswz_pkg;

    localparam int LANES   = 32;
    localparam int ID_W    = $clog2(LANES);
    localparam int DATA_W  = 32;
    localparam int GRP_W   = 3;
    localparam int QSEL_W  = 8;

    typedef enum logic [2:0] {
        SWZ_QUAD  = 3'd0,
        SWZ_MASK  = 3'd1,
        SWZ_BCAST = 3'd2,
        SWZ_SWAP  = 3'd3,
        SWZ_REV   = 3'd4
    } swz_mode_e;

    typedef logic [ID_W-1:0] lane_id_t;

    typedef struct packed {
        logic [2:0]        mode;
        logic [QSEL_W-1:0] quad;
        lane_id_t          and_m;
        lane_id_t          or_m;
        lane_id_t          xor_m;
        logic [GRP_W-1:0]  grp;
        lane_id_t          idx;
    } swz_cfg_t;

    // Low-bit mask with g ones, truncated to a lane id
    function automatic lane_id_t grp_low_mask(logic [GRP_W-1:0] g);
        logic [31:0] m;
        m = (32'd1 << g) - 32'd1;
        return m[ID_W-1:0];
    endfunction

endpackage

// File: rtl/lswz_cfg_check.sv
module lswz_cfg_check
    import lswz_pkg::*;
(
    input  swz_cfg_t cfg,
    output logic     bad
);
    localparam logic [GRP_W-1:0] GMAX = GRP_W'(ID_W);

    lane_id_t above;

    always_comb begin
        above = cfg.idx & ~grp_low_mask(cfg.grp);
        bad   = 1'b0;
        case (cfg.mode)
            SWZ_QUAD, SWZ_MASK: bad = 1'b0;
            SWZ_BCAST: bad = (cfg.grp == '0) || (cfg.grp > GMAX) || (above != '0);
            SWZ_SWAP:  bad = (cfg.grp >= GMAX);
            SWZ_REV:   bad = (cfg.grp == '0) || (cfg.grp > GMAX);
            default:   bad = 1'b1;
        endcase
    end
endmodule

// File: rtl/lswz_index_gen.sv
module lswz_index_gen
    import lswz_pkg::*;
#(
    parameter int N = LANES
) (
    input  swz_cfg_t             cfg,
    output logic [N*ID_W-1:0]    src_ids
);
    for (genvar l = 0; l < N; l++) begin : g_lane
        localparam lane_id_t MY_ID = lane_id_t'(l);
        localparam int       QPOS  = l % 4;
        lane_id_t lo, s;

        always_comb begin
            lo = grp_low_mask(cfg.grp);
            case (cfg.mode)
                SWZ_QUAD:  s = {MY_ID[ID_W-1:2], cfg.quad[2*QPOS +: 2]};
                SWZ_MASK:  s = ((MY_ID & cfg.and_m) | cfg.or_m) ^ cfg.xor_m;
                SWZ_BCAST: s = (MY_ID & ~lo) | (cfg.idx & lo);
                SWZ_SWAP:  s = MY_ID ^ (lo + lane_id_t'(1));
                SWZ_REV:   s = MY_ID ^ lo;
                default:   s = MY_ID;
            endcase
        end

        assign src_ids[l*ID_W +: ID_W] = s;
    end
endmodule

// File: rtl/lswz_xbar.sv
module lswz_xbar
    import lswz_pkg::*;
#(
    parameter int N = LANES,
    parameter int W = DATA_W
) (
    input  logic [N*W-1:0]    din,
    input  logic [N-1:0]      active,
    input  logic [N*ID_W-1:0] src_ids,
    input  logic              bypass,
    output logic [N*W-1:0]    dout
);
    for (genvar l = 0; l < N; l++) begin : g_dst
        lane_id_t       s;
        logic [W-1:0]   picked;

        assign s = src_ids[l*ID_W +: ID_W];

        always_comb begin
            picked = '0;
            for (int k = 0; k < N; k++) begin
                if (s == lane_id_t'(k) && active[k]) picked = din[k*W +: W];
            end
        end

        assign dout[l*W +: W] = bypass ? din[l*W +: W] : picked;
    end
endmodule

// File: rtl/lswz_unit.sv
module lswz_unit
    import lswz_pkg::*;
#(
    parameter int N = LANES,
    parameter int W = DATA_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [N*W-1:0]       lane_data_i,
    input  logic [N-1:0]         active_i,
    input  logic [2:0]           mode_i,
    input  logic [QSEL_W-1:0]    quad_sel_i,
    input  logic [ID_W-1:0]      and_mask_i,
    input  logic [ID_W-1:0]      or_mask_i,
    input  logic [ID_W-1:0]      xor_mask_i,
    input  logic [GRP_W-1:0]     grp_log2_i,
    input  logic [ID_W-1:0]      bcast_idx_i,
    output logic                 out_valid,
    output logic [N*W-1:0]       lane_data_o,
    output logic                 cfg_err_o
);
    swz_cfg_t            cfg;
    logic                bad;
    logic [N*ID_W-1:0]   src_ids;
    logic [N*W-1:0]      perm;

    assign cfg = '{mode: mode_i, quad: quad_sel_i, and_m: and_mask_i,
                   or_m: or_mask_i, xor_m: xor_mask_i, grp: grp_log2_i,
                   idx: bcast_idx_i};

    lswz_cfg_check u_chk_cfg (.cfg(cfg), .bad(bad));

    lswz_index_gen #(.N(N)) u_idx (.cfg(cfg), .src_ids(src_ids));

    lswz_xbar #(.N(N), .W(W)) u_xbar (
        .din(lane_data_i), .active(active_i), .src_ids(src_ids),
        .bypass(bad), .dout(perm)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            lane_data_o <= '0;
            cfg_err_o   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                lane_data_o <= perm;
                cfg_err_o   <= bad;
            end
        end
    end
endmodule

// File: rtl/lswz_unit_chk.sv
module lswz_unit_chk
    import lswz_pkg::*;
#(
    parameter int N = LANES,
    parameter int W = DATA_W
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 in_valid,
    input logic [N*W-1:0]       lane_data_i,
    input logic [N-1:0]         active_i,
    input logic [2:0]           mode_i,
    input logic [GRP_W-1:0]     grp_log2_i,
    input logic [ID_W-1:0]      bcast_idx_i,
    input logic                 out_valid,
    input logic [N*W-1:0]       lane_data_o,
    input logic                 cfg_err_o
);
    logic [W-1:0] swap_src0;
    logic         bad_bcast;

    always_comb begin
        swap_src0 = '0;
        for (int k = 1; k < N; k = k * 2)
            if (32'(k) == (32'd1 << grp_log2_i)) swap_src0 = lane_data_i[k*W +: W];
        bad_bcast = (mode_i == SWZ_BCAST) && (grp_log2_i != '0) &&
                    (grp_log2_i <= GRP_W'(ID_W)) &&
                    ((32'(bcast_idx_i) >> grp_log2_i) != 32'd0);
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && !cfg_err_o && lane_data_o == '0));

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R2
    valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(lane_data_o) && $stable(cfg_err_o)));

    // R6
    swap_lane0_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode_i == SWZ_SWAP && grp_log2_i < GRP_W'(ID_W) && (&active_i))
        |=> lane_data_o[W-1:0] == $past(swap_src0));

    // R8
    rev_inactive_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode_i == SWZ_REV && grp_log2_i == GRP_W'(ID_W) && !active_i[N-1])
        |=> lane_data_o[W-1:0] == '0);

    // R9
    bcast_reject_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && bad_bcast) |=> (cfg_err_o && lane_data_o == $past(lane_data_i)));

    // R10
    mode_reject_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode_i > SWZ_REV) |=> (cfg_err_o && lane_data_o == $past(lane_data_i)));
endmodule

bind lswz_unit lswz_unit_chk #(.N(N), .W(W)) u_unit_chk (.*);

// File: tb/lswz_unit_test.sv
`timescale 1ns/1ps
module lswz_unit_test;
    localparam int N = 32;
    localparam int W = 32;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            in_valid = 1'b0;
    logic [N*W-1:0]  lane_data_i = '0;
    logic [N-1:0]    active_i = '1;
    logic [2:0]      mode_i = '0;
    logic [7:0]      quad_sel_i = '0;
    logic [4:0]      and_mask_i = '0, or_mask_i = '0, xor_mask_i = '0;
    logic [2:0]      grp_log2_i = '0;
    logic [4:0]      bcast_idx_i = '0;
    logic            out_valid;
    logic [N*W-1:0]  lane_data_o;
    logic            cfg_err_o;

    int n_checks = 0;
    int n_fails  = 0;

    always #5 clk = ~clk;

    lswz_unit uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .lane_data_i(lane_data_i),
        .active_i(active_i), .mode_i(mode_i), .quad_sel_i(quad_sel_i),
        .and_mask_i(and_mask_i), .or_mask_i(or_mask_i), .xor_mask_i(xor_mask_i),
        .grp_log2_i(grp_log2_i), .bcast_idx_i(bcast_idx_i),
        .out_valid(out_valid), .lane_data_o(lane_data_o), .cfg_err_o(cfg_err_o)
    );

    task automatic check(string req, logic [N*W-1:0] act, logic [N*W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference mapping written from the requirements; returns 1 on a rejected pattern
    function automatic bit ref_src(int d, int mode, logic [7:0] q, int am, int om, int xm,
                                   int g, int idx, output int s);
        int gs, base, pos;
        gs = 1 << g;
        base = (d / gs) * gs;
        pos = d % gs;
        s = d;
        case (mode)
            0: begin s = (d / 4) * 4 + int'(q[2*(d%4) +: 2]); return 0; end
            1: begin
                s = 0;
                for (int b = 0; b < 5; b++) begin
                    int v;
                    v = (d >> b) & 1;
                    v = (v & (am >> b)) | ((om >> b) & 1);
                    v = (v ^ (xm >> b)) & 1;
                    s = s + (v << b);
                end
                return 0;
            end
            2: begin
                if (g < 1 || g > 5 || idx >= gs) begin s = d; return 1; end
                s = base + idx; return 0;
            end
            3: begin
                if (g > 4) begin s = d; return 1; end
                s = ((d / gs) % 2 == 0) ? d + gs : d - gs; return 0;
            end
            4: begin
                if (g < 1 || g > 5) begin s = d; return 1; end
                s = base + (gs - 1) - pos; return 0;
            end
            default: return 1;
        endcase
    endfunction

    task automatic run_case(string req, int mode, logic [7:0] q, int am, int om, int xm,
                            int g, int idx, logic [N-1:0] act, int seed);
        logic [N*W-1:0] din, exp;
        bit err;
        err = 0;
        for (int k = 0; k < N; k++)
            din[k*W +: W] = (32'(k) * 32'h9E37_79B1) ^ 32'(seed) ^ 32'h0101_0101;
        for (int d = 0; d < N; d++) begin
            int s;
            bit e;
            e = ref_src(d, mode, q, am, om, xm, g, idx, s);
            err = err | e;
        end
        for (int d = 0; d < N; d++) begin
            int s;
            bit e;
            e = ref_src(d, mode, q, am, om, xm, g, idx, s);
            if (err) exp[d*W +: W] = din[d*W +: W];
            else     exp[d*W +: W] = act[s] ? din[s*W +: W] : 32'd0;
        end
        @(negedge clk);
        lane_data_i = din; active_i = act; mode_i = 3'(mode); quad_sel_i = q;
        and_mask_i = 5'(am); or_mask_i = 5'(om); xor_mask_i = 5'(xm);
        grp_log2_i = 3'(g); bcast_idx_i = 5'(idx); in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " data"}, lane_data_o, exp);
        check({req, " err"}, {{(N*W-1){1'b0}}, cfg_err_o}, {{(N*W-1){1'b0}}, err});
        check("R2 valid", {{(N*W-1){1'b0}}, out_valid}, {{(N*W-1){1'b0}}, 1'b1});
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 valid", {{(N*W-1){1'b0}}, out_valid}, '0);
        check("R1 data", lane_data_o, '0);
        check("R1 err", {{(N*W-1){1'b0}}, cfg_err_o}, '0);
    endtask

    task automatic t_quad();
        run_case("R3 quad rev", 0, 8'b00_01_10_11, 0, 0, 0, 0, 0, '1, 11);
        run_case("R3 quad id",  0, 8'hE4, 0, 0, 0, 0, 0, '1, 12);
        run_case("R3 quad p0",  0, 8'h00, 0, 0, 0, 0, 0, '1, 13);
    endtask

    task automatic t_mask();
        run_case("R4 mask keep", 1, 0, 31, 0, 0, 0, 0, '1, 21);
        run_case("R4 mask zero", 1, 0, 0, 0, 0, 0, 0, '1, 22);
        run_case("R4 mask inv",  1, 0, 31, 0, 31, 0, 0, '1, 23);
        run_case("R4 mask mix",  1, 0, 5'h1C, 5'h01, 5'h02, 0, 0, '1, 24);
    endtask

    task automatic t_bcast();
        run_case("R5 bcast g2",  2, 0, 0, 0, 0, 1, 1, '1, 31);
        run_case("R5 bcast g8",  2, 0, 0, 0, 0, 3, 5, '1, 32);
        run_case("R5 bcast g32", 2, 0, 0, 0, 0, 5, 31, '1, 33);
    endtask

    task automatic t_swap();
        for (int g = 0; g < 5; g++) run_case("R6 swap", 3, 0, 0, 0, 0, g, 0, '1, 40 + g);
    endtask

    task automatic t_rev();
        for (int g = 1; g < 6; g++) run_case("R7 reverse", 4, 0, 0, 0, 0, g, 0, '1, 50 + g);
    endtask

    task automatic t_inactive();
        run_case("R8 rev half", 4, 0, 0, 0, 0, 5, 0, 32'h0000_FFFF, 61);
        run_case("R8 all lane0", 1, 0, 0, 0, 0, 0, 0, 32'hFFFF_FFFE, 62);
        run_case("R8 quad gaps", 0, 8'h1B, 0, 0, 0, 0, 0, 32'h0F0F_0F0F, 63);
    endtask

    task automatic t_bad_idx();
        run_case("R9 idx4 g4", 2, 0, 0, 0, 0, 2, 4, 32'h5555_5555, 71);
        run_case("R9 idx2 g2", 2, 0, 0, 0, 0, 1, 2, 32'h0000_0000, 72);
    endtask

    task automatic t_bad_code();
        run_case("R10 mode5",  5, 0, 0, 0, 0, 1, 0, 32'h00FF_00FF, 81);
        run_case("R10 mode7",  7, 0, 0, 0, 0, 1, 0, '1, 82);
        run_case("R10 swap5",  3, 0, 0, 0, 0, 5, 0, '1, 83);
        run_case("R10 rev0",   4, 0, 0, 0, 0, 0, 0, '1, 84);
        run_case("R10 bcast6", 2, 0, 0, 0, 0, 6, 0, '1, 85);
        run_case("R10 clears", 4, 0, 0, 0, 0, 2, 0, '1, 86);
    endtask

    task automatic t_hold();
        logic [N*W-1:0] held;
        logic           herr;
        run_case("R2 setup", 3, 0, 0, 0, 0, 2, 0, '1, 91);
        held = lane_data_o;
        herr = cfg_err_o;
        @(negedge clk);
        lane_data_i = ~lane_data_i; mode_i = 3'd6;
        @(negedge clk);
        @(negedge clk);
        check("R2 hold data", lane_data_o, held);
        check("R2 hold err", {{(N*W-1){1'b0}}, cfg_err_o}, {{(N*W-1){1'b0}}, herr});
        check("R2 idle valid", {{(N*W-1){1'b0}}, out_valid}, '0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        @(negedge clk);
        rst = 1'b0;
        t_quad();
        t_mask();
        t_bcast();
        t_swap();
        t_rev();
        t_inactive();
        t_bad_idx();
        t_bad_code();
        t_hold();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        #2_000_000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule